// File: doc/BRIEF.md
# USB Connection Speed Discriminator

This block settles the connection speed of a USB link at the end of a bus reset and shows it in a 2-bit speed status. High-speed enable, a bus-reset-active flag, the 2-bit line state and a handshake-complete signal drive it. The handshake-complete signal reports that the termination has switched to high-speed mode. The chirp signalling is done elsewhere; only its outcome enters here.

With high-speed disabled, the status reads full-speed at once and no handshake is followed. With high-speed enabled, each new bus reset clears the status to undecided and arms a pending result. That result resolves at one of two moments. A high-speed device resolves it during reset, when the handshake reports the termination switch. A full-speed device resolves it when the bus moves from SE0 to J. If the cable is pulled during reset, no such event arrives. The status then stays undecided, and software reads the line state to learn why.

All pins are plain control and status signals with no flow control. The status is registered, so it changes one clock after the inputs that cause the change.

Top module: `usb_speed_discriminator`

## Requirements
- R1: While `rst_n` is low the status is 00 (undecided) and no result is pending.
- R2: When `hs_enable` is 0, the status is 10 (full-speed) after the next clock edge. Bus reset, line state and `hs_term` have no effect while it stays 0.
- R3: When `hs_enable` is 1, a rising `bus_reset` clears the status to 00 at the next edge and arms a pending result. This holds even if `hs_term` is high in that cycle.
- R4: With a result pending and `bus_reset` high, `hs_term` high sets the status to 11 (high-speed) at that edge.
- R5: With a result pending, a sampled line state of SE0 (00) followed by J (01) on the next sample sets the status to 10 at the edge that samples J. K (10) and a K-to-J change do not count.
- R6: If the R4 and R5 conditions occur in the same cycle, high-speed (11) wins.
- R7: If no handshake and no SE0-to-J change follow a reset, the status stays 00 after reset ends.
- R8: Once a result is decided, further SE0-to-J changes and `hs_term` pulses leave the status unchanged until the next reset begins.
- R9: `hs_term` while `bus_reset` is low has no effect.
- R10: Dropping `hs_enable` while a result is pending gives 10 and cancels the pending result. Raising `hs_enable` again keeps the status until a new reset begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_enable | input | 1 | High-speed operation allowed |
| bus_reset | input | 1 | USB bus reset in progress |
| line_state | input | 2 | Bus line state: 00 SE0, 01 J, 10 K |
| hs_term | input | 1 | Handshake done, termination switched to high-speed |
| speed_status | output | 2 | 00 undecided, 10 full-speed, 11 high-speed |

## Verification
The handshake report and the SE0-to-J change can land in the same cycle. The bench provokes this by raising `hs_term` on the cycle whose line state goes from SE0 to J while `bus_reset` is still high. The scoreboard expects high-speed at that edge. A second collision puts a reset start and `hs_term` in one cycle and expects undecided, followed by high-speed one cycle later.

// File: rtl/usb_spd_pkg.sv
package usb_spd_pkg;
  localparam int LS_W  = 2;
  localparam int SPD_W = 2;

  typedef enum logic [LS_W-1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [SPD_W-1:0] {
    SPD_UND = 2'b00,
    SPD_RSV = 2'b01,
    SPD_FS  = 2'b10,
    SPD_HS  = 2'b11
  } speed_t;
endpackage

// File: rtl/spd_line_edge.sv
module spd_line_edge
  import usb_spd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LS_W-1:0] line_state,
  output logic            se0_to_j
);
  logic [LS_W-1:0] ls_q;

  // The previous sample resets to J, so leaving reset never looks like an SE0 exit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ls_q <= LS_J;
    else        ls_q <= line_state;
  end

  assign se0_to_j = (ls_q == LS_SE0) && (line_state == LS_J);

  // R5: an exit from SE0 is only seen when the previous sample was SE0
  a_r5_edge_from_se0: assert property (@(posedge clk) disable iff (!rst_n)
    se0_to_j |-> $past(line_state) == LS_SE0);
endmodule

// File: rtl/spd_reset_edge.sv
module spd_reset_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  output logic reset_start
);
  logic busrst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busrst_q <= 1'b0;
    else        busrst_q <= bus_reset;
  end

  assign reset_start = bus_reset && !busrst_q;

  // R3: a start pulse never repeats on two adjacent cycles
  a_r3_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    reset_start |=> !reset_start);
endmodule

// File: rtl/spd_resolver.sv
module spd_resolver
  import usb_spd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_enable,
  input  logic       bus_reset,
  input  logic       reset_start,
  input  logic       hs_term,
  input  logic       se0_to_j,
  output speed_t     status
);
  logic   pending_q;
  logic   pending_d;
  speed_t status_d;
  logic   hs_hit;
  logic   fs_hit;

  // A result can resolve only while one is still pending.
  assign hs_hit = pending_q && bus_reset && hs_term;
  assign fs_hit = pending_q && se0_to_j;

  always_comb begin
    status_d  = status;
    pending_d = pending_q;
    if (!hs_enable) begin
      status_d  = SPD_FS;
      pending_d = 1'b0;
    end else if (reset_start) begin
      status_d  = SPD_UND;
      pending_d = 1'b1;
    end else if (hs_hit) begin
      status_d  = SPD_HS;
      pending_d = 1'b0;
    end else if (fs_hit) begin
      status_d  = SPD_FS;
      pending_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= SPD_UND;
      pending_q <= 1'b0;
    end else begin
      status    <= status_d;
      pending_q <= pending_d;
    end
  end

  a_r2_fs_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_enable |=> status == SPD_FS);

  a_r3_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    hs_enable && reset_start |=> status == SPD_UND && pending_q);

  a_r4_hs_on_term: assert property (@(posedge clk) disable iff (!rst_n)
    hs_enable && !reset_start && pending_q && bus_reset && hs_term |=> status == SPD_HS);

  a_r5_fs_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    hs_enable && !reset_start && pending_q && !(bus_reset && hs_term) && se0_to_j
    |=> status == SPD_FS);

  a_r8_hold_when_decided: assert property (@(posedge clk) disable iff (!rst_n)
    hs_enable && !pending_q && !reset_start |=> $stable(status));

  // R1: the reserved code never appears
  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    status != SPD_RSV);
endmodule

// File: rtl/usb_speed_discriminator.sv
module usb_speed_discriminator
  import usb_spd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_enable,
  input  logic             bus_reset,
  input  logic [LS_W-1:0]  line_state,
  input  logic             hs_term,
  output logic [SPD_W-1:0] speed_status
);
  logic   se0_to_j;
  logic   reset_start;
  speed_t status;

  spd_line_edge u_line_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_state (line_state),
    .se0_to_j   (se0_to_j)
  );

  spd_reset_edge u_reset_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_reset   (bus_reset),
    .reset_start (reset_start)
  );

  spd_resolver u_resolver (
    .clk         (clk),
    .rst_n       (rst_n),
    .hs_enable   (hs_enable),
    .bus_reset   (bus_reset),
    .reset_start (reset_start),
    .hs_term     (hs_term),
    .se0_to_j    (se0_to_j),
    .status      (status)
  );

  assign speed_status = status;

  // R9: the handshake outside reset never produces high-speed from undecided
  a_r9_term_needs_reset: assert property (@(posedge clk) disable iff (!rst_n)
    hs_enable && !bus_reset && speed_status == SPD_UND |=> speed_status != SPD_HS);
endmodule

// File: tb/usb_speed_discriminator_tb.sv
module usb_speed_discriminator_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_enable = 1'b1;
  logic       bus_reset = 1'b0;
  logic [1:0] line_state = 2'b01;
  logic       hs_term = 1'b0;
  logic [1:0] speed_status;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10;
  localparam logic [1:0] UND = 2'b00, FS = 2'b10, HS = 2'b11;

  always #4 clk = ~clk;

  usb_speed_discriminator u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .hs_enable    (hs_enable),
    .bus_reset    (bus_reset),
    .line_state   (line_state),
    .hs_term      (hs_term),
    .speed_status (speed_status)
  );

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: speed_status=%b expected=%b", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of inputs and queue the status expected after that edge.
  task automatic cyc(input logic hse, input logic br, input logic [1:0] ls,
                     input logic term, input logic [1:0] exp, input string tag);
    @(negedge clk);
    hs_enable  = hse;
    bus_reset  = br;
    line_state = ls;
    hs_term    = term;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare the registered status shortly after each edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      check(speed_status, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(speed_status, UND, "R1 reset state");
    @(negedge clk) rst_n = 1'b1;

    // Idle, then reset with handshake
    cyc(1, 0, J,   0, UND, "R1 idle after reset");
    cyc(1, 1, SE0, 0, UND, "R3 reset start");
    cyc(1, 1, SE0, 0, UND, "R3 pending in reset");
    cyc(1, 1, SE0, 1, HS,  "R4 handshake");
    cyc(1, 1, SE0, 0, HS,  "R4 hold");
    cyc(1, 0, J,   0, HS,  "R8 exit ignored after HS");

    // Full-speed device
    cyc(1, 1, SE0, 0, UND, "R3 clear previous HS");
    cyc(1, 1, SE0, 0, UND, "R3 pending");
    cyc(1, 0, SE0, 0, UND, "R5 still SE0");
    cyc(1, 0, J,   0, FS,  "R5 SE0 to J");
    cyc(1, 0, SE0, 1, FS,  "R8 R9 term ignored after FS");
    cyc(1, 0, J,   0, FS,  "R8 second exit ignored");

    // K and K-to-J do not count
    cyc(1, 1, SE0, 0, UND, "R3 reset start");
    cyc(1, 0, K,   0, UND, "R5 K ignored");
    cyc(1, 0, J,   0, UND, "R5 K to J ignored");
    cyc(1, 0, SE0, 0, UND, "R5 back to SE0");
    cyc(1, 0, J,   0, FS,  "R5 SE0 to J after K");

    // Cable pulled: term outside reset, line stuck at SE0
    cyc(1, 1, SE0, 0, UND, "R3 reset start");
    cyc(1, 0, SE0, 0, UND, "R7 reset over");
    cyc(1, 0, SE0, 1, UND, "R9 term outside reset");
    for (int i = 0; i < 5; i++) cyc(1, 0, SE0, 0, UND, "R7 stays undecided");

    // Collision of handshake and SE0 exit
    cyc(1, 1, SE0, 0, UND, "R3 reset start");
    cyc(1, 1, SE0, 0, UND, "R3 pending");
    cyc(1, 1, J,   1, HS,  "R6 HS wins collision");

    // High-speed disabled
    cyc(0, 1, SE0, 0, FS,  "R2 disabled gives FS");
    cyc(0, 0, J,   1, FS,  "R2 term ignored");
    cyc(0, 1, SE0, 1, FS,  "R2 reset start ignored");
    cyc(1, 1, SE0, 0, FS,  "R10 re-enable keeps status");
    cyc(1, 0, J,   0, FS,  "R10 keep");

    // Reset start and term in one cycle, then disable during pending
    cyc(1, 1, SE0, 1, UND, "R3 start beats term");
    cyc(1, 1, SE0, 1, HS,  "R4 term next cycle");
    cyc(1, 0, J,   0, HS,  "R8 hold");
    cyc(1, 1, SE0, 0, UND, "R3 reset start");
    cyc(0, 1, SE0, 0, FS,  "R10 drop enable while pending");
    cyc(1, 1, SE0, 1, FS,  "R10 pending cancelled");
    cyc(1, 0, SE0, 0, FS,  "R10 hold");
    cyc(1, 0, J,   0, FS,  "R10 exit ignored");

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule